// File: doc/BRIEF.md
# Three-Wire Dual Wiper Setting Register

This block is the serial front end for a pair of 256-step digital potentiometer channels. A host drives three wires: an active-high enable, a serial clock and a data line. While the enable is high, each rising edge of the serial clock shifts one data bit into a 17-bit frame register. The frame holds a stack-select flag and one 8-bit wiper code for each channel. When the enable drops, the frame is copied into the wiper outputs. The outputs keep their old values for the whole time the enable is high.

All three wires are sampled through synchronizers on a fast system clock. Serial-clock edges and the enable release are detected from the sampled values. The bit leaving the far end of the frame register drives a serial output, so several blocks can be chained on one enable and clock. The stack-select flag picks which channel's wiper reaches a combined tap output. It also forms the top bit of a 9-bit stacked position, giving 512 positions when the two channels are used in series.

Top module: `dual_wiper_serial_port`

## Requirements
- R1: A frame is 17 bits sent in this order: the stack-select flag first, then the channel-1 wiper code MSB first, then the channel-0 wiper code MSB first. Each bit is sampled on a serial-clock rising edge while the enable is high.
- R2: While the enable is high, including the time after the last bit of a frame has been shifted in, the wiper, stack-select, combined-tap and stacked-position outputs do not change.
- R3: The frame register is copied to the outputs when the enable falls. The new values appear no later than SYNC_STAGES+2 system clock cycles after the enable wire goes low.
- R4: Serial-clock edges that arrive while the enable is low do not change the frame register. This is visible on the serial output and on the values latched at the next enable release.
- R5: The stack-select flag is bit 0 of the frame register, which is the first bit of the frame. When the flag is 0 the combined tap output shows the channel-0 wiper. When it is 1, the combined tap shows the channel-1 wiper.
- R6: The stacked position output is 9 bits: the stack-select flag is the MSB, and the wiper code chosen by the flag forms the low 8 bits.
- R7: The serial output always shows the oldest bit held in the frame register. After exactly 17 bits it equals the stack-select flag of that frame. With two blocks chained, a 34-bit transfer sets up both, and the block nearest the host takes the later 17 bits.
- R8: A transfer that is not a multiple of 17 bits is not corrected. The register simply holds the last 17 bits received across transfers, and that is what gets latched. A transfer of a whole multiple of 17 bits leaves the last frame in place.
- R9: The wiper outputs need no particular value after reset. The combined tap and stacked position still follow R5 and R6 from reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Active-high transfer enable; its falling edge applies the frame |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Oldest bit of the frame register, for chaining |
| wiper0_o | output | 8 | Channel-0 wiper code |
| wiper1_o | output | 8 | Channel-1 wiper code |
| stack_sel_o | output | 1 | Latched stack-select flag |
| combo_wiper_o | output | 8 | Wiper code of the channel chosen by stack-select |
| stacked_pos_o | output | 9 | Stack-select flag on top of the chosen wiper code |

## Verification
The bench sweeps many frames that contain boundary codes and varied bit patterns. After each bit it checks that nothing moved, which catches a design that writes the wipers while the frame is still arriving. A design that swaps the channel order, reverses the bit order or misplaces the flag produces crossed or mirrored wiper codes. The bench toggles the serial clock with the enable low and then releases the enable with no clocks; a block that shifts on stray edges then shows a wrong serial output and wrong latched codes. A 16-bit transfer and a 34-bit chained transfer check that misalignment is carried forward rather than repaired, and that the chained block receives the earlier half of the stream.

// File: rtl/dwsr_pkg.sv
package dwsr_pkg;
  parameter int WIPER_W_DEF     = 8;
  parameter int SYNC_STAGES_DEF = 2;
  // wire index inside the synchronizer bundle
  parameter int WIRE_EN  = 0;
  parameter int WIRE_CLK = 1;
  parameter int WIRE_DIN = 2;
  parameter int N_WIRES  = 3;
endpackage

// File: rtl/dwsr_sync.sv
module dwsr_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced,
  output logic [N-1:0] rose,
  output logic [N-1:0] fell
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_wire
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], raw[i]};
      end
      assign synced[i] = chain[STAGES-1];
      assign rose[i]   = chain[STAGES-1] & ~chain[STAGES];
      assign fell[i]   = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/dwsr_shifter.sv
module dwsr_shifter #(
  parameter int FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_evt,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic               dout
);
  logic [FRAME_W-1:0] sr;

  // new bit enters at the top; the first bit of a frame ends at position 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (shift_evt) sr <= {din, sr[FRAME_W-1:1]};
  end

  assign frame = sr;
  assign dout  = sr[0];

  assert_idle_clock_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(sr));
  assert_bit_enters_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> frame[FRAME_W-1] == $past(din));
  assert_oldest_bit_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> dout == $past(frame[1]));
endmodule

// File: rtl/dwsr_latch.sv
module dwsr_latch #(
  parameter int WIPER_W = 8,
  localparam int FRAME_W = 1 + 2 * WIPER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_evt,
  input  logic [FRAME_W-1:0] frame,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               stack_sel
);
  // a field sent MSB first starting at register position base:
  // its MSB sits at base, its LSB at base+WIPER_W-1
  function automatic logic [WIPER_W-1:0] field_at(input logic [FRAME_W-1:0] f,
                                                  input int base);
    logic [WIPER_W-1:0] v;
    for (int k = 0; k < WIPER_W; k++) v[WIPER_W-1-k] = f[base+k];
    return v;
  endfunction

  logic [WIPER_W-1:0] next_w1, next_w0;
  assign next_w1 = field_at(frame, 1);
  assign next_w0 = field_at(frame, 1 + WIPER_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper0    <= '0;
      wiper1    <= '0;
      stack_sel <= 1'b0;
    end else if (latch_evt) begin
      wiper0    <= next_w0;
      wiper1    <= next_w1;
      stack_sel <= frame[0];
    end
  end

  assert_hold_between_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable({wiper1, wiper0, stack_sel}));
  assert_flag_from_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> stack_sel == $past(frame[0]));
  assert_w1_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> wiper1[WIPER_W-1] == $past(frame[1]));
endmodule

// File: rtl/dwsr_tap_mux.sv
module dwsr_tap_mux #(
  parameter int WIPER_W = 8
) (
  input  logic               stack_sel,
  input  logic [WIPER_W-1:0] wiper0,
  input  logic [WIPER_W-1:0] wiper1,
  output logic [WIPER_W-1:0] combo,
  output logic [WIPER_W:0]   stacked_pos
);
  function automatic logic [WIPER_W-1:0] pick(input logic s,
                                              input logic [WIPER_W-1:0] a,
                                              input logic [WIPER_W-1:0] b);
    return s ? b : a;
  endfunction

  assign combo       = pick(stack_sel, wiper0, wiper1);
  assign stacked_pos = {stack_sel, combo};
endmodule

// File: rtl/dual_wiper_serial_port.sv
module dual_wiper_serial_port #(
  parameter int WIPER_W     = dwsr_pkg::WIPER_W_DEF,
  parameter int SYNC_STAGES = dwsr_pkg::SYNC_STAGES_DEF,
  localparam int FRAME_W    = 1 + 2 * WIPER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_en,
  input  logic               ser_clk,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               stack_sel_o,
  output logic [WIPER_W-1:0] combo_wiper_o,
  output logic [WIPER_W:0]   stacked_pos_o
);
  import dwsr_pkg::*;

  logic [N_WIRES-1:0] raw, synced, rose, fell;
  assign raw[WIRE_EN]  = ser_en;
  assign raw[WIRE_CLK] = ser_clk;
  assign raw[WIRE_DIN] = ser_din;

  dwsr_sync #(.N(N_WIRES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw),
    .synced(synced), .rose(rose), .fell(fell)
  );

  // named internal events
  logic shift_evt, latch_evt, din_s;
  assign shift_evt = rose[WIRE_CLK] & synced[WIRE_EN];
  assign latch_evt = fell[WIRE_EN];
  assign din_s     = synced[WIRE_DIN];

  logic [FRAME_W-1:0] frame;
  dwsr_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .din(din_s),
    .frame(frame), .dout(ser_dout)
  );

  dwsr_latch #(.WIPER_W(WIPER_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .frame(frame),
    .wiper0(wiper0_o), .wiper1(wiper1_o), .stack_sel(stack_sel_o)
  );

  dwsr_tap_mux #(.WIPER_W(WIPER_W)) u_mux (
    .stack_sel(stack_sel_o), .wiper0(wiper0_o), .wiper1(wiper1_o),
    .combo(combo_wiper_o), .stacked_pos(stacked_pos_o)
  );

  assert_pos_top_is_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stacked_pos_o[WIPER_W] == stack_sel_o);
  assert_no_shift_and_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |-> !shift_evt);
endmodule

// File: tb/tb_dual_wiper_serial_port.sv
module tb_dual_wiper_serial_port;
  logic clk = 0, rst_n = 0, ser_en = 0, ser_clk = 0, ser_din = 0;
  logic ser_dout, far_dout;
  logic [7:0] w0, w1, cw, fw0, fw1, fcw;
  logic sel, fsel;
  logic [8:0] pos, fpos;
  int n_checks = 0, n_fail = 0;
  logic [16:0] hist = '0;   // last 17 bits sent to the near block, oldest at bit 16

  always #4 clk = ~clk;     // 125 MHz

  dual_wiper_serial_port dut (.clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .wiper0_o(w0), .wiper1_o(w1),
    .stack_sel_o(sel), .combo_wiper_o(cw), .stacked_pos_o(pos));
  dual_wiper_serial_port dut_far (.clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_dout), .ser_dout(far_dout), .wiper0_o(fw0), .wiper1_o(fw1),
    .stack_sel_o(fsel), .combo_wiper_o(fcw), .stacked_pos_o(fpos));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame vector {flag, w1, w0}: flag sent first, both codes MSB first
  task automatic expect_frame(input string req, input logic [16:0] f,
                              input logic [7:0] a0, input logic [7:0] a1, input logic as,
                              input logic [7:0] ac, input logic [8:0] ap);
    logic [7:0] e0, e1, ec;
    e1 = f[15:8]; e0 = f[7:0];
    ec = f[16] ? e1 : e0;
    chk(as == f[16], {req, " R5 flag"}, as, f[16]);
    chk(a1 == e1, {req, " R1 wiper1"}, a1, e1);
    chk(a0 == e0, {req, " R1 wiper0"}, a0, e0);
    chk(ac == ec, {req, " R5 combo"}, ac, ec);
    chk(ap == {f[16], ec}, {req, " R6 pos"}, ap, {f[16], ec});
  endtask

  task automatic send_bit(input logic b, input bit watch, input logic [25:0] snap);
    ser_din = b;
    if (ser_en) hist = {hist[15:0], b};
    waitn(5); ser_clk = 1; waitn(5); ser_clk = 0;
    if (watch) chk({w1, w0, sel} == snap, "R2 hold while shifting", {w1, w0, sel}, snap);
  endtask

  task automatic transfer(input logic [33:0] bits, input int nbits, input string req);
    logic [25:0] snap;
    ser_en = 1; waitn(5);
    snap = {w1, w0, sel};
    for (int i = nbits - 1; i >= 0; i--) send_bit(bits[i], 1'b1, snap);
    waitn(10);
    chk({w1, w0, sel} == snap, "R2 hold after last bit", {w1, w0, sel}, snap);
    chk(ser_dout == hist[16], "R7 dout oldest bit", ser_dout, hist[16]);
    ser_en = 0; waitn(4);   // SYNC_STAGES+2 cycles
    expect_frame({req, " R3 latch on release"}, hist, w0, w1, sel, cw, pos);
    waitn(6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [16:0] f;
    logic [25:0] snap;
    logic [16:0] far_f, near_f;
    waitn(3); rst_n = 1; waitn(3);
    // R9: no reset value assumed, only consistency of derived outputs
    chk(cw == (sel ? w1 : w0), "R9 combo after reset", cw, sel ? w1 : w0);
    chk(pos == {sel, (sel ? w1 : w0)}, "R9 pos after reset", pos, {sel, (sel ? w1 : w0)});

    // boundary frames
    transfer({17'h0, 17'h00000}, 17, "zeros");
    transfer({17'h0, 17'h1FFFF}, 17, "ones");
    transfer({17'h0, {1'b0, 8'hFF, 8'h00}}, 17, "R5 sel0 w1=FF");
    transfer({17'h0, {1'b1, 8'h00, 8'hFF}}, 17, "R5 sel1 w0=FF");
    transfer({17'h0, {1'b1, 8'h80, 8'h01}}, 17, "R1 msb/lsb");

    // sweep
    for (int i = 0; i < 64; i++) begin
      f = {i[0], 8'((i * 91 + 200) & 255), 8'((i * 37 + 5) & 255)};
      transfer({17'h0, f}, 17, "sweep");
    end

    // R4: stray clocks with enable low
    snap = {w1, w0, sel};
    for (int i = 0; i < 17; i++) send_bit(i[0] ^ i[2], 1'b1, snap);
    chk(ser_dout == hist[16], "R4 dout after stray clocks", ser_dout, hist[16]);
    ser_en = 1; waitn(10); ser_en = 0; waitn(10);
    expect_frame("R4 release without clocks", hist, w0, w1, sel, cw, pos);

    // R8: misaligned 16-bit transfer carries the previous leftover bit
    transfer({18'h0, 16'hA5C3}, 16, "R8 16-bit");
    // R8: 34-bit transfer on one block keeps the last 17 bits
    transfer({17'h0A5F0, 17'h1C33C}, 34, "R8 34-bit");

    // R7: chained pair, far block gets the first half
    far_f  = {1'b1, 8'h3C, 8'hD2};
    near_f = {1'b0, 8'h5A, 8'h81};
    transfer({far_f, near_f}, 34, "R7 chain near");
    expect_frame("R7 chain far", far_f, fw0, fw1, fsel, fcw, fpos);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule